// File: doc/BRIEF.md
# I2C Pin Ownership Override

This block sits between an I2C controller and the SCL/SDA pads and decides who drives the two lines. By default the controller owns both pins, and its open-drain pull-low enables pass straight through to the pads. Software can write one ownership bit and take both pins away from the controller at the same time. After that, each pin is driven from a software output latch, and a per-pin direction bit decides whether the latch can pull the line low. The usual use is bus recovery: SCL is made an output and toggled, SDA is left as an input and watched, and then ownership goes back to the controller.

The output latch is changed through two write-only strobe registers. Writing a one to a bit of the set register releases that line. Writing a one to a bit of the clear register pulls that line low. Neither needs a read-modify-write. A level register always shows the pad levels through a two-flop synchronizer, whichever side owns the pins.

Ownership is a two-state machine. In OWN_ENGINE the controller drives the pads. In OWN_SOFT the software latch drives them. There are two transitions, both taken only on a write to the mode offset: TAKE (OWN_ENGINE to OWN_SOFT) when bit 0 of the written data is 1, and GIVE (OWN_SOFT to OWN_ENGINE) when bit 0 is 0.

Top module: `i2c_pin_override`

## Requirements
- R1: Reset state. After reset the owner is OWN_ENGINE. Both direction bits are 0. Both latch bits are 1 (released). The level register reads 0 until the synchronizer fills.
- R2: In OWN_ENGINE, pad_scl_oe equals eng_scl_oe and pad_sda_oe equals eng_sda_oe, in the same cycle and combinationally.
- R3: A write to offset 0 with data bit 0 set takes both pins to OWN_SOFT together. A write with bit 0 clear returns them to OWN_ENGINE. The other data bits are ignored. Offset 0 reads back the owner in bit 0 (1 = OWN_SOFT), with zeros in all other bits.
- R4: Offset 1 holds the direction bits: bit 0 for SCL, bit 1 for SDA, where 1 means output. In OWN_SOFT, a pin whose direction bit is 0 is released (pad oe 0), whatever its latch holds. A pin whose direction bit is 1 has pad oe equal to the inverse of its latch bit (open drain).
- R5: Writing data to offset 3 (set) makes latch bit 0 (SCL) and latch bit 1 (SDA) 1 wherever the data bit is 1. A latch bit whose data bit is 0 is left unchanged.
- R6: Writing data to offset 4 (clear) makes latch bit 0 (SCL) and latch bit 1 (SDA) 0 wherever the data bit is 1. A latch bit whose data bit is 0 is left unchanged. The new latch value is visible at the pads in the cycle after the write.
- R7: Offset 2 reads the pad levels (bit 0 SCL, bit 1 SDA). Each level appears two clock edges after it is present at the pad input, in both ownership states.
- R8: In OWN_SOFT, the controller enables have no effect on the pad enables.
- R9: Offsets 3, 4 and any unused offset read as zero. The latch and the direction bits keep their values across ownership changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write offset |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 3 | Read offset |
| bus_rdata | output | 8 | Read data, combinational from bus_raddr |
| eng_scl_oe | input | 1 | Controller pull-low enable for SCL |
| eng_sda_oe | input | 1 | Controller pull-low enable for SDA |
| pad_scl_in | input | 1 | Sensed SCL level |
| pad_sda_in | input | 1 | Sensed SDA level |
| pad_scl_oe | output | 1 | Final SCL pull-low enable |
| pad_sda_oe | output | 1 | Final SDA pull-low enable |

## Verification
The controller enables are swept through all four combinations in both ownership states. This separates pass-through from the software path and shows that the controller is blocked in OWN_SOFT. The latch is driven with set and clear masks of zero, one bit and both bits, under the recovery direction pattern (SCL out, SDA in) and the all-output pattern. This tells a write that changes only the addressed bit apart from one that touches its neighbour. The pad inputs are toggled with the read offset parked on the level register, which exposes the synchronizer latency in each ownership state.

// File: rtl/i2c_pinovr_pkg.sv
package i2c_pinovr_pkg;
    localparam int NPINS  = 2;
    localparam int PIN_SCL = 0;
    localparam int PIN_SDA = 1;

    localparam logic [2:0] OFS_OWNER = 3'd0;
    localparam logic [2:0] OFS_DIR   = 3'd1;
    localparam logic [2:0] OFS_LEVEL = 3'd2;
    localparam logic [2:0] OFS_SET   = 3'd3;
    localparam logic [2:0] OFS_CLR   = 3'd4;

    typedef enum logic {
        OWN_ENGINE = 1'b0,
        OWN_SOFT   = 1'b1
    } pin_owner_e;
endpackage

// File: rtl/pinovr_sync.sv
module pinovr_sync #(
    parameter int NPINS  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] synced
);
    localparam int WARM_W = $clog2(STAGES + 1);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], raw[p]};
        end
        assign synced[p] = chain[STAGES-1];
    end

    logic [WARM_W-1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   warm <= '0;
        else if (warm != WARM_W'(STAGES)) warm <= warm + 1'b1;
    end

    // R7
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == WARM_W'(STAGES)) |-> (synced == $past(raw, STAGES)));
endmodule

// File: rtl/pinovr_owner_fsm.sv
module pinovr_owner_fsm
    import i2c_pinovr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic       mode_bit,
    output pin_owner_e owner
);
    pin_owner_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWN_ENGINE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_ENGINE: if (mode_wr &&  mode_bit) state_d = OWN_SOFT;   // TAKE
            OWN_SOFT:   if (mode_wr && !mode_bit) state_d = OWN_ENGINE; // GIVE
            default:    state_d = OWN_ENGINE;
        endcase
    end

    assign owner = state_q;

    // R3
    take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_bit) |=> (owner == OWN_SOFT));
    // R3
    give_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !mode_bit) |=> (owner == OWN_ENGINE));
endmodule

// File: rtl/pinovr_regs.sv
module pinovr_regs
    import i2c_pinovr_pkg::*;
#(
    parameter int NPINS  = 2,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  pin_owner_e        owner,
    input  logic [NPINS-1:0]  level,
    output logic              mode_wr,
    output logic              mode_bit,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  latch
);
    localparam int PAD_W = DATA_W - NPINS;

    logic             set_hit, clr_hit, dir_hit;
    logic [NPINS-1:0] set_mask, clr_mask;

    assign mode_wr  = wr && (waddr == ADDR_W'(OFS_OWNER));
    assign mode_bit = wdata[0];
    assign dir_hit  = wr && (waddr == ADDR_W'(OFS_DIR));
    assign set_hit  = wr && (waddr == ADDR_W'(OFS_SET));
    assign clr_hit  = wr && (waddr == ADDR_W'(OFS_CLR));
    assign set_mask = set_hit ? wdata[NPINS-1:0] : '0;
    assign clr_mask = clr_hit ? wdata[NPINS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir   <= '0;
            latch <= '1;
        end else begin
            if (dir_hit) dir <= wdata[NPINS-1:0];
            latch <= (latch | set_mask) & ~clr_mask;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (raddr)
            ADDR_W'(OFS_OWNER): rdata = {{(DATA_W-1){1'b0}}, owner == OWN_SOFT};
            ADDR_W'(OFS_DIR):   rdata = {{PAD_W{1'b0}}, dir};
            ADDR_W'(OFS_LEVEL): rdata = {{PAD_W{1'b0}}, level};
            default:            rdata = '0;
        endcase
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_chk
        // R5
        set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_hit && wdata[p]) |=> latch[p]);
        // R6
        clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && wdata[p]) |=> !latch[p]);
        // R5
        set_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_hit && !wdata[p]) |=> $stable(latch[p]));
    end
endmodule

// File: rtl/pinovr_padmux.sv
module pinovr_padmux
    import i2c_pinovr_pkg::*;
#(
    parameter int NPINS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pin_owner_e       owner,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] latch,
    input  logic [NPINS-1:0] eng_oe,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        always_comb begin
            unique case (owner)
                OWN_ENGINE: pad_oe[p] = eng_oe[p];
                OWN_SOFT:   pad_oe[p] = dir[p] & ~latch[p];
                default:    pad_oe[p] = eng_oe[p];
            endcase
        end

        // R8
        soft_blocks_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (owner == OWN_SOFT && $stable(owner) && $stable(dir) && $stable(latch))
            |-> $stable(pad_oe[p]));
        // R4
        input_pin_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (owner == OWN_SOFT && !dir[p]) |-> !pad_oe[p]);
    end
endmodule

// File: rtl/i2c_pin_override.sv
module i2c_pin_override
    import i2c_pinovr_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_scl_oe,
    input  logic              eng_sda_oe,
    input  logic              pad_scl_in,
    input  logic              pad_sda_in,
    output logic              pad_scl_oe,
    output logic              pad_sda_oe
);
    pin_owner_e       owner;
    logic             mode_wr, mode_bit;
    logic [NPINS-1:0] dir, latch, level, raw, eng_oe, pad_oe;

    assign raw[PIN_SCL]    = pad_scl_in;
    assign raw[PIN_SDA]    = pad_sda_in;
    assign eng_oe[PIN_SCL] = eng_scl_oe;
    assign eng_oe[PIN_SDA] = eng_sda_oe;
    assign pad_scl_oe      = pad_oe[PIN_SCL];
    assign pad_sda_oe      = pad_oe[PIN_SDA];

    pinovr_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw), .synced(level)
    );

    pinovr_owner_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bit(mode_bit), .owner(owner)
    );

    pinovr_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .waddr(bus_waddr), .wdata(bus_wdata),
        .raddr(bus_raddr), .rdata(bus_rdata), .owner(owner), .level(level),
        .mode_wr(mode_wr), .mode_bit(mode_bit), .dir(dir), .latch(latch)
    );

    pinovr_padmux #(.NPINS(NPINS)) u_mux (
        .clk(clk), .rst_n(rst_n), .owner(owner), .dir(dir), .latch(latch),
        .eng_oe(eng_oe), .pad_oe(pad_oe)
    );
endmodule

// File: tb/i2c_pin_override_tb.sv
module i2c_pin_override_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_waddr = '0;
    logic [7:0] bus_wdata = '0;
    logic [2:0] bus_raddr = '0;
    logic [7:0] bus_rdata;
    logic       eng_scl_oe = 1'b0, eng_sda_oe = 1'b0;
    logic       pad_scl_in = 1'b1, pad_sda_in = 1'b1;
    logic       pad_scl_oe, pad_sda_oe;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit   m_soft;
    bit   m_dir [2];
    bit   m_latch [2];
    bit   hist_scl [$];
    bit   hist_sda [$];

    always #4 clk = ~clk;

    i2c_pin_override u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe),
        .pad_scl_in(pad_scl_in), .pad_sda_in(pad_sda_in),
        .pad_scl_oe(pad_scl_oe), .pad_sda_oe(pad_sda_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_oe(input int p, input bit eng);
        if (m_soft) return m_dir[p] && !m_latch[p];
        return eng;
    endfunction

    function automatic int exp_rdata(input int a);
        case (a)
            0: return int'(m_soft);
            1: return int'(m_dir[1]) * 2 + int'(m_dir[0]);
            2: return int'(hist_sda[0]) * 2 + int'(hist_scl[0]);
            default: return 0;
        endcase
    endfunction

    // reference model step and per-cycle comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            m_soft = 0;
            m_dir = '{0, 0};
            m_latch = '{1, 1};
            hist_scl = '{0, 0};
            hist_sda = '{0, 0};
        end else begin
            if (bus_wr) begin
                case (int'(bus_waddr))
                    0: m_soft = bus_wdata[0];
                    1: begin m_dir[0] = bus_wdata[0]; m_dir[1] = bus_wdata[1]; end
                    3: for (int p = 0; p < 2; p++) if (bus_wdata[p]) m_latch[p] = 1;
                    4: for (int p = 0; p < 2; p++) if (bus_wdata[p]) m_latch[p] = 0;
                    default: ;
                endcase
            end
            hist_scl.push_back(pad_scl_in); void'(hist_scl.pop_front());
            hist_sda.push_back(pad_sda_in); void'(hist_sda.pop_front());
        end
        #2;
        if (rst_n) begin
            check(m_soft ? "R4 scl" : "R2 scl", pad_scl_oe, exp_oe(0, eng_scl_oe));
            check(m_soft ? "R4 sda" : "R2 sda", pad_sda_oe, exp_oe(1, eng_sda_oe));
            check(bus_raddr == 2 ? "R7 read" : (bus_raddr > 2 ? "R9 read" : "R3 read"),
                  bus_rdata, exp_rdata(int'(bus_raddr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = 3'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk); #3;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        bus_raddr = 3'd0; settle(); check("R1 owner", bus_rdata, 0);
        @(negedge clk) bus_raddr = 3'd1; settle(); check("R1 dir", bus_rdata, 0);
        // R2 pass-through, all enable combinations
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); eng_scl_oe = v[0]; eng_sda_oe = v[1];
            settle();
            check("R2 scl", pad_scl_oe, v[0]);
            check("R2 sda", pad_sda_oe, v[1]);
        end
        // R3 take ownership; upper bits ignored
        wr(0, 8'hF1); bus_raddr = 3'd0; settle(); check("R3 take", bus_rdata, 1);
        // R4 inputs by default: released, R1 latch released
        check("R4 released scl", pad_scl_oe, 0);
        check("R4 released sda", pad_sda_oe, 0);
        // recovery pattern: SCL out, SDA in
        wr(1, 1); wr(4, 3);
        settle();
        check("R6 scl low", pad_scl_oe, 1);
        check("R4 sda input", pad_sda_oe, 0);
        // R8 controller ignored
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); eng_scl_oe = v[0]; eng_sda_oe = v[1];
            settle();
            check("R8 scl", pad_scl_oe, 1);
            check("R8 sda", pad_sda_oe, 0);
        end
        // R5 zero data has no effect; then set SCL
        wr(3, 0); settle(); check("R5 zero set", pad_scl_oe, 1);
        wr(3, 1); settle(); check("R5 set scl", pad_scl_oe, 0);
        // both outputs; clear SDA only
        wr(1, 3); wr(4, 2); settle();
        check("R6 sda low", pad_sda_oe, 1);
        check("R6 scl kept", pad_scl_oe, 0);
        wr(4, 0); settle(); check("R6 zero clear", pad_sda_oe, 1);
        // R9 give back and retake: latch and dir retained
        @(negedge clk); eng_scl_oe = 1'b1; eng_sda_oe = 1'b0;
        wr(0, 8'hFE); settle();
        check("R3 give", pad_scl_oe, 1);
        check("R3 give sda", pad_sda_oe, 0);
        wr(0, 1); settle();
        check("R9 latch kept", pad_sda_oe, 1);
        check("R9 latch kept scl", pad_scl_oe, 0);
        bus_raddr = 3'd3; settle(); check("R9 set reads 0", bus_rdata, 0);
        @(negedge clk) bus_raddr = 3'd4; settle(); check("R9 clr reads 0", bus_rdata, 0);
        @(negedge clk) bus_raddr = 3'd7; settle(); check("R9 unused reads 0", bus_rdata, 0);
        // R7 level latency in soft mode then engine mode
        for (int m = 0; m < 2; m++) begin
            if (m == 1) wr(0, 0);
            @(negedge clk); bus_raddr = 3'd2; pad_scl_in = 1'b0; pad_sda_in = 1'b1;
            repeat (3) @(negedge clk);
            check("R7 settled", bus_rdata, 2);
            pad_scl_in = 1'b1; pad_sda_in = 1'b0;
            @(posedge clk); #3; check("R7 one edge", bus_rdata, 2);
            @(posedge clk); #3; check("R7 two edges", bus_rdata, 1);
        end
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule